// File: doc/BRIEF.md
# SPI Master Shift Engine with Bus Self-Check

This block is an SPI master that moves one 8-bit word per transfer, most significant bit first. The serial clock idles low, launches data on its falling edge and samples on its rising edge. The serial clock period is an even multiple of the system clock. A transfer begins on a start pulse, which carries the transmit word and a format select. The received word appears together with a one-cycle done strobe.

While the master drives its data-out pad, it monitors that pad through the pad's input buffer. At every rising serial-clock edge, half a serial period after each bit is launched, it compares the pad level with the bit it meant to send. A mismatch raises a sticky bit-error flag. The flag drives the interrupt output only when the error interrupt enable is high.

A small per-format table selects half duplex. When the selected entry is set, the data-out pad is released for the whole transfer and serves as the receive line, and the master-in pad is ignored. A loop-back setting routes the transmit stream straight into the receive shifter and keeps every pad at its idle level. Software may write this setting only while the engine is idle.

Top module: `spi_selfcheck_master`

## Requirements
- R1: With the defaults, `sclk_o` is low whenever `busy` is low. During a transfer each bit spends HALF_DIV cycles low and then HALF_DIV cycles high. `mosi_o` carries the transmit word MSB first and changes only at the start of each bit's low half. `busy` stays high for 2*HALF_DIV*8 cycles.
- R2: In full duplex, each received bit is sampled from `miso_i` in the last system cycle before the serial clock rises. `rx_word` holds the assembled word, MSB first, in the cycle in which `done` is high.
- R3: When the data-out pad is driven, `mosi_i` is compared with the intended bit at every rising-edge sample point. A mismatch sets `bit_err` on the next cycle.
- R4: No compare takes place while the data-out pad is released (half duplex or loop-back). A wrong level on `mosi_i` then leaves `bit_err` at 0.
- R5: `irq` is high only when `bit_err` is 1 and `err_ie` is 1.
- R6: `bit_err` stays at 1 until a cycle with `err_clr` high. A mismatch in the same cycle as `err_clr` keeps it at 1.
- R7: A transfer is half duplex when `fmt_hdx[fmt_sel]`, captured at start, is 1. `mosi_oe` then stays 0 for the whole transfer, and the data is received from `mosi_i` instead of `miso_i`.
- R8: With `loop_en` at 1, the transmit word is received unchanged, while `sclk_o`, `mosi_o` and `mosi_oe` all stay at 0.
- R9: A `loop_wr` pulse loads `loop_val` into `loop_en` only when `busy` is low. A pulse during a transfer is ignored.
- R10: A `start` pulse while `busy` is high is ignored. The running transfer continues unchanged.
- R11: `done` is high for exactly one cycle per transfer, in the cycle in which `busy` has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted while idle) |
| tx_word | input | WORD_W | Word to transmit |
| fmt_sel | input | FSEL_W | Format index for this transfer |
| fmt_hdx | input | NUM_FMT | Half-duplex enable, one bit per format |
| loop_wr | input | 1 | Write strobe for the loop-back setting |
| loop_val | input | 1 | Value written to the loop-back setting |
| err_ie | input | 1 | Bit-error interrupt enable |
| err_clr | input | 1 | Write-one-to-clear strobe for the bit error |
| miso_i | input | 1 | Master-in pad |
| mosi_i | input | 1 | Input-buffer reading of the master-out pad |
| sclk_o | output | 1 | Serial clock pad |
| mosi_o | output | 1 | Master-out pad data |
| mosi_oe | output | 1 | Master-out pad drive enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer strobe |
| rx_word | output | WORD_W | Last received word |
| bit_err | output | 1 | Sticky bit-error flag |
| irq | output | 1 | Gated bit-error interrupt |
| loop_en | output | 1 | Current loop-back setting |

## Verification
The bench forces the pad reading away from the driven level during a transfer, with the interrupt enable first off and then on. This catches a monitor that reads the shifter instead of the pad, and an interrupt that ignores its enable. It holds the clear strobe across a corrupted transfer, so a clear that beats the set would leave a cycle with the flag at 0. In half-duplex and loop-back transfers it places a level on the pad that differs from the transmit bit and puts junk on the master-in pad. A design that keeps comparing, or that receives from the wrong pin, would raise the flag or return the wrong word. It also writes the loop-back setting and pulses start in the middle of a transfer, where a design that accepts either would change the pad activity or restart the shifter.

// File: rtl/spi_sc_pkg.sv
package spi_sc_pkg;

  typedef enum logic [1:0] {
    RX_FROM_MISO = 2'd0,
    RX_FROM_MOSI = 2'd1,
    RX_FROM_TX   = 2'd2
  } rx_src_e;

  // Loop-back wins over half duplex; both override the normal master-in pin.
  function automatic rx_src_e pick_rx_src(input logic loop, input logic hdx);
    if (loop) return RX_FROM_TX;
    if (hdx)  return RX_FROM_MOSI;
    return RX_FROM_MISO;
  endfunction

  // The data-out pad is driven only during a full-duplex, non-loop transfer.
  function automatic logic pad_drives(input logic busy, input logic loop, input logic hdx);
    return busy & ~loop & ~hdx;
  endfunction

  // Mismatch between the pad level read back and the bit meant to be sent.
  function automatic logic pad_mismatch(input logic pad, input logic want);
    return pad ^ want;
  endfunction

endpackage

// File: rtl/spi_sc_clkgen.sv
module spi_sc_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk_q,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic phase_end;

  assign phase_end = run && (cnt == CNT_LAST);
  assign rise_evt  = phase_end & ~sclk_q;
  assign fall_evt  = phase_end &  sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (phase_end) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_sc_shifter.sv
module spi_sc_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              rx_bit,
  output logic              tx_bit,
  output logic [WORD_W-1:0] rx_shift,
  output logic              last_fall
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);

  logic [WORD_W-1:0] tx_sh;
  logic [CW-1:0]     bit_cnt;

  assign tx_bit    = tx_sh[WORD_W-1];
  assign last_fall = fall_evt && (bit_cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_shift <= '0;
      bit_cnt  <= '0;
    end else if (load) begin
      tx_sh    <= load_word;
      rx_shift <= '0;
      bit_cnt  <= '0;
    end else begin
      if (rise_evt) rx_shift <= {rx_shift[WORD_W-2:0], rx_bit};
      if (fall_evt) begin
        tx_sh   <= {tx_sh[WORD_W-2:0], 1'b0};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_sc_errmon.sv
module spi_sc_errmon
  import spi_sc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  input  logic drive_en,
  input  logic pad_bit,
  input  logic want_bit,
  input  logic clr,
  input  logic ie,
  output logic bit_err,
  output logic irq,
  output logic mismatch_evt
);
  assign mismatch_evt = rise_evt & drive_en & pad_mismatch(pad_bit, want_bit);
  assign irq          = bit_err & ie;

  // A new mismatch has priority over the clear strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            bit_err <= 1'b0;
    else if (mismatch_evt) bit_err <= 1'b1;
    else if (clr)          bit_err <= 1'b0;
  end
endmodule

// File: rtl/spi_selfcheck_master.sv
module spi_selfcheck_master
  import spi_sc_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int HALF_DIV = 2,
  parameter int NUM_FMT  = 2,
  localparam int FSEL_W  = (NUM_FMT > 1) ? $clog2(NUM_FMT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [FSEL_W-1:0] fmt_sel,
  input  logic [NUM_FMT-1:0] fmt_hdx,
  input  logic              loop_wr,
  input  logic              loop_val,
  input  logic              err_ie,
  input  logic              err_clr,
  input  logic              miso_i,
  input  logic              mosi_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              mosi_oe,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              bit_err,
  output logic              irq,
  output logic              loop_en
);
  logic              busy_q, done_q, loop_q, hdx_q;
  logic [WORD_W-1:0] rx_q;
  logic              start_acc, fmt_hdx_pick;
  logic              sclk_q, rise_evt, fall_evt;
  logic              tx_bit, rx_bit, last_fall, drive_en, mismatch_evt;
  logic [WORD_W-1:0] rx_shift;
  rx_src_e           rx_src;

  assign start_acc = start & ~busy_q;

  always_comb begin
    fmt_hdx_pick = 1'b0;
    for (int i = 0; i < NUM_FMT; i++)
      if (fmt_sel == FSEL_W'(i)) fmt_hdx_pick = fmt_hdx[i];
  end

  spi_sc_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy_q),
    .sclk_q(sclk_q), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  assign rx_src = pick_rx_src(loop_q, hdx_q);
  always_comb begin
    case (rx_src)
      RX_FROM_TX:   rx_bit = tx_bit;
      RX_FROM_MOSI: rx_bit = mosi_i;
      default:      rx_bit = miso_i;
    endcase
  end

  spi_sc_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .load_word(tx_word),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .rx_bit(rx_bit),
    .tx_bit(tx_bit), .rx_shift(rx_shift), .last_fall(last_fall)
  );

  assign drive_en = pad_drives(busy_q, loop_q, hdx_q);

  spi_sc_errmon u_err (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .drive_en(drive_en),
    .pad_bit(mosi_i), .want_bit(tx_bit), .clr(err_clr), .ie(err_ie),
    .bit_err(bit_err), .irq(irq), .mismatch_evt(mismatch_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      hdx_q  <= 1'b0;
      loop_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      done_q <= last_fall;
      if (start_acc) begin
        busy_q <= 1'b1;
        hdx_q  <= fmt_hdx_pick;
      end else if (last_fall) begin
        busy_q <= 1'b0;
      end
      if (last_fall) rx_q <= rx_shift;
      if (loop_wr && !busy_q) loop_q <= loop_val;
    end
  end

  assign sclk_o  = sclk_q & ~loop_q;
  assign mosi_oe = drive_en;
  assign mosi_o  = drive_en & tx_bit;
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_q;
  assign loop_en = loop_q;
endmodule

// File: rtl/spi_sc_checker.sv
module spi_sc_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic sclk_o,
  input logic mosi_o,
  input logic mosi_oe,
  input logic loop_en,
  input logic bit_err,
  input logic irq,
  input logic err_ie,
  input logic err_clr,
  input logic hdx_q,
  input logic mismatch_evt
);
  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_o);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));
  // R8
  loop_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (!sclk_o && !mosi_oe && !mosi_o));
  // R7
  hdx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hdx_q) |-> !mosi_oe);
  // R9
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(loop_en));
  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_evt |=> bit_err);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_err && !err_clr) |=> bit_err);
  // R4
  err_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_err) |-> $past(mosi_oe));
  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_ie |-> !irq);
endmodule

bind spi_selfcheck_master spi_sc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sclk_o(sclk_o),
  .mosi_o(mosi_o), .mosi_oe(mosi_oe), .loop_en(loop_en), .bit_err(bit_err),
  .irq(irq), .err_ie(err_ie), .err_clr(err_clr), .hdx_q(hdx_q),
  .mismatch_evt(mismatch_evt)
);

// File: tb/spi_selfcheck_master_bench.sv
`timescale 1ns/1ps
module spi_selfcheck_master_bench;
  localparam int H = 2;
  localparam int W = 8;
  localparam int XFER = 2 * H * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       start = 0, loop_wr = 0, loop_val = 0, err_ie = 0, err_clr = 0;
  logic [7:0] tx_word = 0;
  logic [0:0] fmt_sel = 0;
  logic [1:0] fmt_hdx = 2'b10;
  logic       miso_i, mosi_i;
  logic       sclk_o, mosi_o, mosi_oe, busy, done, bit_err, irq, loop_en;
  logic [7:0] rx_word;

  // bench stimulus for the far side of the bus
  logic [7:0] slave_word = 0;
  logic       corrupt = 0;

  // reference model state
  logic       m_busy, m_done, m_loop, m_hdx, m_err, m_set;
  logic [7:0] m_tx, m_rxword;
  int         m_t;
  int         checks = 0, fails = 0, cyc = 0;

  function automatic int bit_idx(input int t);
    int b = t / (2 * H);
    return (b > W - 1) ? W - 1 : b;
  endfunction

  logic slave_bit;
  assign slave_bit = slave_word[W - 1 - bit_idx(m_t)];
  assign miso_i    = m_hdx ? ~slave_bit : slave_bit;
  assign mosi_i    = mosi_oe ? (mosi_o ^ corrupt) : slave_bit;

  spi_selfcheck_master #(.WORD_W(W), .HALF_DIV(H), .NUM_FMT(2)) u_spi_selfcheck_master (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .fmt_sel(fmt_sel),
    .fmt_hdx(fmt_hdx), .loop_wr(loop_wr), .loop_val(loop_val), .err_ie(err_ie),
    .err_clr(err_clr), .miso_i(miso_i), .mosi_i(mosi_i), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .busy(busy), .done(done), .rx_word(rx_word),
    .bit_err(bit_err), .irq(irq), .loop_en(loop_en)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural reference, advanced on every rising clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_loop <= 0; m_hdx <= 0; m_err <= 0;
      m_tx <= 0; m_rxword <= 0; m_t <= 0;
    end else begin
      m_set = 0;
      if (m_busy) begin
        if ((m_t % (2 * H)) == H - 1 && !m_loop && !m_hdx && corrupt) m_set = 1;
        if (m_t == XFER - 1) begin
          m_busy <= 0; m_done <= 1;
          m_rxword <= m_loop ? m_tx : slave_word;
        end else begin
          m_t <= m_t + 1; m_done <= 0;
        end
      end else begin
        m_done <= 0;
        if (start) begin
          m_busy <= 1; m_t <= 0; m_tx <= tx_word; m_hdx <= fmt_hdx[fmt_sel];
        end
      end
      if (loop_wr && !m_busy) m_loop <= loop_val;
      if (m_set) m_err <= 1;
      else if (err_clr) m_err <= 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_oe;
      e_oe = m_busy && !m_loop && !m_hdx;
      check("R1 sclk_o", sclk_o, m_busy && !m_loop && (((m_t / H) % 2) == 1));
      check("R1 mosi_o", mosi_o, e_oe && m_tx[W - 1 - bit_idx(m_t)]);
      check("R7 mosi_oe", mosi_oe, e_oe);
      check("R10 busy", busy, m_busy);
      check("R11 done", done, m_done);
      check("R3 bit_err", bit_err, m_err);
      check("R5 irq", irq, m_err && err_ie);
      check("R9 loop_en", loop_en, m_loop);
      if (m_done) check("R2 rx_word", rx_word, m_rxword);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL R11 watchdog: got busy=%0d expected a finished run", busy);
      summary();
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wait_end();
    while (!m_done) step(1);
    step(1);
  endtask

  task automatic run_word(input logic [7:0] tx, input logic [7:0] sw, input logic sel);
    tx_word = tx; slave_word = sw; fmt_sel = sel; start = 1;
    step(1);
    start = 0;
    wait_end();
  endtask

  initial begin
    step(2);
    // R1 reset state
    check("R1 reset sclk_o", sclk_o, 0);
    check("R10 reset busy", busy, 0);
    check("R3 reset bit_err", bit_err, 0);
    rst_n = 1;
    step(2);

    // R1 R2 full duplex, several patterns
    run_word(8'hA5, 8'h3C, 0);
    check("R2 rx A5/3C", rx_word, 8'h3C);
    run_word(8'h00, 8'hFF, 0);
    run_word(8'hFF, 8'h00, 0);
    run_word(8'h81, 8'h7E, 0);
    check("R2 rx 81/7E", rx_word, 8'h7E);

    // R3 R5 corrupted pad, interrupt disabled then enabled
    corrupt = 1;
    run_word(8'h5A, 8'h11, 0);
    corrupt = 0;
    check("R3 bit_err after mismatch", bit_err, 1);
    check("R5 irq masked", irq, 0);
    err_ie = 1;
    step(1);
    check("R5 irq enabled", irq, 1);
    // R6 clear
    err_clr = 1; step(1); err_clr = 0; step(1);
    check("R6 cleared", bit_err, 0);
    // R6 set beats clear while clear is held
    err_clr = 1; corrupt = 1;
    run_word(8'hC3, 8'h22, 0);
    err_clr = 0; corrupt = 0;
    check("R6 held clear ends at 0", bit_err, 0);

    // R7 R4 half duplex via format 1; pad level differs from tx bits
    run_word(8'h5A, 8'hA5, 1);
    check("R7 hdx rx from mosi pad", rx_word, 8'hA5);
    check("R4 no compare in hdx", bit_err, 0);
    run_word(8'h0F, 8'h0F, 0);
    check("R7 back to full duplex", rx_word, 8'h0F);

    // R8 R4 loop-back
    loop_wr = 1; loop_val = 1; step(1); loop_wr = 0;
    check("R9 loop write idle", loop_en, 1);
    run_word(8'h96, 8'h69, 0);
    check("R8 loop rx", rx_word, 8'h96);
    check("R4 no compare in loop", bit_err, 0);

    // R9 write during transfer ignored
    tx_word = 8'h3E; slave_word = 8'h01; start = 1; step(1); start = 0;
    step(5);
    loop_wr = 1; loop_val = 0; step(1); loop_wr = 0;
    wait_end();
    check("R9 loop write while busy ignored", loop_en, 1);
    check("R8 loop rx 3E", rx_word, 8'h3E);
    loop_wr = 1; loop_val = 0; step(1); loop_wr = 0;
    check("R9 loop cleared idle", loop_en, 0);

    // R10 start during transfer ignored
    tx_word = 8'hB4; slave_word = 8'h4B; fmt_sel = 0; start = 1; step(1); start = 0;
    step(7);
    tx_word = 8'hFF; start = 1; step(1); start = 0;
    wait_end();
    check("R10 second start ignored", rx_word, 8'h4B);
    check("R10 idle after one word", busy, 0);

    step(4);
    summary();
  end
endmodule